// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block watches a host processor for signs of life. Software loads an eight-bit control byte with a steering bit, a five-bit multiplier and a two-bit resolution code. From those fields the block derives a timeout, counted in ticks of a 16 Hz time base supplied from outside. The host restarts the count by toggling a kick pin or by writing the control byte again. If the count runs out, the block sets a watchdog flag. It then takes one of two actions, chosen by the steering bit. The first is an active-low interrupt that stays latched until software writes zero to the control byte. The second is an active-low reset pulse of fixed length, which clears itself and also clears the control byte.

The interrupt output is shared with a frequency-test waveform that comes from elsewhere in the chip. The watchdog takes that pin whenever it is aimed at the interrupt and enabled, or has an interrupt latched. A one-cycle strobe asks the owner of the frequency-test enable to drop it when a reset-steered timeout completes. A read strobe from the flags register clears the flag. Bus decode, the oscillator and the divider that produces the tick are outside the block.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the flag is 0, `irq_ft_n` and `rst_out_n` are 1, and `ft_clr` is 0.
- R2: The control byte is laid out as bit 7 = steering, bits 6:2 = multiplier and bits 1:0 = resolution. Resolution codes 0, 1, 2 and 3 give 1, 4, 16 and 64 ticks per unit. The timeout is multiplier × unit ticks, counted from the last restart. The flag rises at the clock edge that samples the tick completing the count.
- R3: A multiplier of zero stops counting, so no timeout ever occurs.
- R4: A rising or a falling edge on `kick` restarts the count. The edge takes effect three clock edges after the pin changes (two synchroniser flops, then edge detection).
- R5: Every write loads `wr_data` into the control byte and restarts the count. A write in the same cycle as a completing tick cancels that timeout.
- R6: A timeout sets `wd_flag`. A cycle with `flag_rd` high clears it, but a timeout in that same cycle wins.
- R7: A timeout with steering 0 latches an interrupt that holds `irq_ft_n` low. Only a write of 0x00 releases it.
- R8: A timeout with steering 1 drives `rst_out_n` low from the next clock edge. It returns high at the edge that samples the PULSE_TICKS-th following tick (default 2 ticks, 125 ms).
- R9: A timeout with steering 1 clears the control byte to 0x00 and raises `ft_clr` for exactly one cycle, both at the same edge as the reset pulse starts.
- R10: The watchdog owns `irq_ft_n` when an interrupt is latched, or when steering is 0 and the multiplier is nonzero. While it owns the pin, the pin shows the inverse of the latch. Otherwise the pin follows `ft_wave` if `ft_en` is 1, and is 1 if not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| tick16 | input | 1 | One-cycle strobe at the 16 Hz base rate |
| kick | input | 1 | Asynchronous service pin; either edge restarts the count |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| flag_rd | input | 1 | Flags register read strobe |
| ft_en | input | 1 | Frequency-test enable from its owning register |
| ft_wave | input | 1 | Frequency-test waveform |
| wd_flag | output | 1 | Watchdog flag |
| irq_ft_n | output | 1 | Shared active-low interrupt / frequency-test pin |
| rst_out_n | output | 1 | Active-low reset pulse |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test enable |
| cfg_q | output | 8 | Current control byte |

## Verification
The checks assume the following about the inputs:
- `tick16` is a single-cycle strobe.
- `wr_en`, `flag_rd`, `ft_en` and `ft_wave` change only between clock edges.
- `kick` may toggle at any time, but it is never expected to act before its synchroniser delay.

The stimulus drives every input on the falling clock edge. It holds ticks to one cycle and spaces them by random gaps. It moves `kick` by whole toggles, so that each toggle forms exactly one edge. Written bytes use small multipliers, so that timeouts, flag reads and rewrites all occur often within the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Which source currently drives the shared interrupt / test pin.
   typedef enum logic [1:0] {
      PIN_IDLE  = 2'd0,
      PIN_WDOG  = 2'd1,
      PIN_FTEST = 2'd2
   } wdt_pin_src_e;

   // Width of the elapsed-tick counter: largest multiplier shifted by the
   // largest resolution exponent.
   function automatic int wdt_cnt_width(int mult_w, int res_w, int step);
      return mult_w + step * ((1 << res_w) - 1);
   endfunction

   // Width needed to hold the reset pulse tick count.
   function automatic int wdt_pulse_width(int ticks);
      return (ticks < 2) ? 1 : $clog2(ticks + 1);
   endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic edge_o
);

   // chain[STAGES-1:0] are synchroniser flops, chain[STAGES] the history flop
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign edge_o = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int MULT_W   = 5,
   parameter int RES_W    = 2,
   parameter int RES_STEP = 2,
   parameter int CNT_W    = 11
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart,
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic              armed,
   output logic              expire,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  limit_o
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   generate
      if (RES_STEP == 0) begin : g_flat
         logic unused_res;
         assign unused_res = ^res;
         assign limit = CNT_W'(mult);
      end else begin : g_scaled
         assign limit = CNT_W'(mult) << (RES_STEP * int'(res));
      end
   endgenerate

   assign armed  = |mult;
   assign expire = tick & armed & ~restart & (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= '0;
      else if (expire)         cnt <= '0;
      else if (tick && armed)  cnt <= cnt + 1'b1;
   end

   assign cnt_o   = cnt;
   assign limit_o = limit;

endmodule

// File: rtl/wdt_outputs.sv
module wdt_outputs
   import wdt_pkg::*;
#(
   parameter int PULSE_TICKS = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic expire,
   input  logic steer,
   input  logic armed,
   input  logic wr_zero,
   input  logic flag_rd,
   input  logic ft_en,
   input  logic ft_wave,
   output logic flag_o,
   output logic irq_lat_o,
   output logic rst_out_n,
   output logic ft_clr,
   output logic pin_n
);

   localparam int PW = wdt_pulse_width(PULSE_TICKS);

   logic          flag, irq_lat, clr_q;
   logic [PW-1:0] pcnt;
   wdt_pin_src_e  src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         irq_lat <= 1'b0;
         clr_q   <= 1'b0;
         pcnt    <= '0;
      end else begin
         if (expire)       flag <= 1'b1;
         else if (flag_rd) flag <= 1'b0;

         if (expire && !steer) irq_lat <= 1'b1;
         else if (wr_zero)     irq_lat <= 1'b0;

         clr_q <= expire & steer;

         if (expire && steer)          pcnt <= PW'(PULSE_TICKS);
         else if (tick && pcnt != '0)  pcnt <= pcnt - 1'b1;
      end
   end

   always_comb begin
      if (irq_lat || (!steer && armed)) src = PIN_WDOG;
      else if (ft_en)                   src = PIN_FTEST;
      else                              src = PIN_IDLE;
   end

   always_comb begin
      case (src)
         PIN_WDOG:  pin_n = ~irq_lat;
         PIN_FTEST: pin_n = ft_wave;
         default:   pin_n = 1'b1;
      endcase
   end

   assign flag_o    = flag;
   assign irq_lat_o = irq_lat;
   assign rst_out_n = (pcnt == '0);
   assign ft_clr    = clr_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdt_pkg::*;
#(
   parameter  int MULT_W      = 5,
   parameter  int RES_W       = 2,
   parameter  int RES_STEP    = 2,
   parameter  int PULSE_TICKS = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int CFG_W       = 1 + MULT_W + RES_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             kick,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             flag_rd,
   input  logic             ft_en,
   input  logic             ft_wave,
   output logic             wd_flag,
   output logic             irq_ft_n,
   output logic             rst_out_n,
   output logic             ft_clr,
   output logic [CFG_W-1:0] cfg_q
);

   localparam int CNT_W = wdt_cnt_width(MULT_W, RES_W, RES_STEP);

   generate
      if (PULSE_TICKS < 1 || PULSE_TICKS > 3) begin : g_bad_pulse
         $error("PULSE_TICKS must keep the pulse within 40..200 ms at 16 Hz");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MULT_W < 1 || RES_W < 1 || RES_W > 3) begin : g_bad_width
         $error("MULT_W must be >= 1 and RES_W within 1..3");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg;
   logic              steer, armed, expire, kick_edge, restart, wr_zero, irq_lat;
   logic [MULT_W-1:0] mult;
   logic [RES_W-1:0]  res;
   logic [CNT_W-1:0]  cnt, limit;

   assign steer   = cfg[CFG_W-1];
   assign mult    = cfg[CFG_W-2:RES_W];
   assign res     = cfg[RES_W-1:0];
   assign restart = wr_en | kick_edge;
   assign wr_zero = wr_en & (wr_data == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cfg <= '0;
      else if (wr_en)           cfg <= wr_data;
      else if (expire && steer) cfg <= '0;
   end

   wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(kick), .edge_o(kick_edge)
   );

   wdt_timebase #(
      .MULT_W(MULT_W), .RES_W(RES_W), .RES_STEP(RES_STEP), .CNT_W(CNT_W)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .restart(restart),
      .mult(mult), .res(res), .armed(armed), .expire(expire),
      .cnt_o(cnt), .limit_o(limit)
   );

   wdt_outputs #(.PULSE_TICKS(PULSE_TICKS)) u_out (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .expire(expire),
      .steer(steer), .armed(armed), .wr_zero(wr_zero), .flag_rd(flag_rd),
      .ft_en(ft_en), .ft_wave(ft_wave), .flag_o(wd_flag),
      .irq_lat_o(irq_lat), .rst_out_n(rst_out_n), .ft_clr(ft_clr),
      .pin_n(irq_ft_n)
   );

   assign cfg_q = cfg;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int CFG_W = 8,
   parameter int CNT_W = 11,
   parameter int RES_W = 2
)(
   input logic             clk,
   input logic             rst_n,
   input logic             tick16,
   input logic             wr_en,
   input logic [CFG_W-1:0] wr_data,
   input logic             wd_flag,
   input logic             irq_ft_n,
   input logic             rst_out_n,
   input logic             ft_clr,
   input logic [CFG_W-1:0] cfg_q,
   input logic             irq_lat,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] limit
);

   // R2
   cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cfg_q[CFG_W-2:RES_W]) |-> (cnt < limit));

   // R3
   idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_q[CFG_W-2:RES_W] == '0) |-> !$rose(wd_flag));

   // R5
   write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == '0));

   // R6
   pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n) |-> wd_flag);

   // R7
   zero_write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == '0) |=> !irq_lat);

   // R8
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_out_n && !tick16) |=> !rst_out_n);

   // R9
   ftclr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ft_clr |-> (cfg_q == '0 && !rst_out_n));

   // R10
   pin_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lat |-> !irq_ft_n);

endmodule

bind wdog_timer wdog_timer_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
   .wd_flag(wd_flag), .irq_ft_n(irq_ft_n), .rst_out_n(rst_out_n),
   .ft_clr(ft_clr), .cfg_q(cfg_q), .irq_lat(irq_lat), .cnt(cnt), .limit(limit)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;

   localparam int PT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick16 = 1'b0, kick = 1'b0, wr_en = 1'b0, flag_rd = 1'b0;
   logic ft_en = 1'b0, ft_wave = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic wd_flag, irq_ft_n, rst_out_n, ft_clr;
   logic [7:0] cfg_q;

   int vectors = 0, miscompares = 0, cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   wdog_timer i_wdog_timer (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .kick(kick), .wr_en(wr_en),
      .wr_data(wr_data), .flag_rd(flag_rd), .ft_en(ft_en), .ft_wave(ft_wave),
      .wd_flag(wd_flag), .irq_ft_n(irq_ft_n), .rst_out_n(rst_out_n),
      .ft_clr(ft_clr), .cfg_q(cfg_q)
   );

   // Reference model built from the requirements
   logic [7:0]  m_cfg;
   logic [10:0] m_cnt;
   logic [1:0]  m_pcnt;
   logic        m_flag, m_irq, m_clr, k0, k1, k2;

   function automatic logic [10:0] limit_of(logic [7:0] c);
      return 11'(c[6:2]) << (2 * int'(c[1:0]));  // R2 unit = 1,4,16,64 ticks
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 0; m_cnt = 0; m_pcnt = 0; m_flag = 0; m_irq = 0; m_clr = 0;
         k0 = 0; k1 = 0; k2 = 0;
      end else begin
         logic kedge, restart, ex, on;
         kedge   = k1 ^ k2;
         k2 = k1; k1 = k0; k0 = kick;
         on      = (m_cfg[6:2] != 0);
         restart = wr_en | kedge;
         ex      = tick16 && on && !restart && (m_cnt == limit_of(m_cfg) - 11'd1);
         m_clr   = ex && m_cfg[7];
         if (ex && m_cfg[7])            m_pcnt = 2'(PT);
         else if (tick16 && m_pcnt != 0) m_pcnt = m_pcnt - 2'd1;
         if (ex)           m_flag = 1;
         else if (flag_rd) m_flag = 0;
         if (ex && !m_cfg[7])               m_irq = 1;
         else if (wr_en && wr_data == 8'h00) m_irq = 0;
         if (restart || ex)   m_cnt = 0;
         else if (tick16 && on) m_cnt = m_cnt + 11'd1;
         if (wr_en)               m_cfg = wr_data;
         else if (ex && m_cfg[7]) m_cfg = 0;
      end
   end

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic compare_all();
      logic own, pin;
      own = m_irq | (!m_cfg[7] && m_cfg[6:2] != 0);
      pin = own ? !m_irq : (ft_en ? ft_wave : 1'b1);
      chk("R6 wd_flag", 32'(wd_flag), 32'(m_flag));
      chk("R10 irq_ft_n", 32'(irq_ft_n), 32'(pin));
      chk("R8 rst_out_n", 32'(rst_out_n), 32'(m_pcnt == 0));
      chk("R9 ft_clr", 32'(ft_clr), 32'(m_clr));
      chk("R5 cfg_q", 32'(cfg_q), 32'(m_cfg));
   endtask

   // one cycle: compare at the falling edge, then drive new inputs
   task automatic step(logic tk, logic we, logic [7:0] wd, logic fr);
      @(negedge clk);
      if (rst_n) compare_all();
      tick16 = tk; wr_en = we; wr_data = wd; flag_rd = fr;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin step(1, 0, 0, 0); step(0, 0, 0, 0); end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1607));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 0);
      // R1 reset state
      chk("R1 cfg_q", 32'(cfg_q), 0);
      chk("R1 wd_flag", 32'(wd_flag), 0);
      chk("R1 irq_ft_n", 32'(irq_ft_n), 1);
      chk("R1 rst_out_n", 32'(rst_out_n), 1);
      chk("R1 ft_clr", 32'(ft_clr), 0);

      // R2: 0x05 -> mult 1, unit 4 ticks, steering 0
      step(0, 1, 8'h05, 0); step(0, 0, 0, 0);
      ticks(3);
      chk("R2 early flag", 32'(wd_flag), 0);
      ticks(1);
      chk("R2 flag at 4 ticks", 32'(wd_flag), 1);
      chk("R7 irq asserted", 32'(irq_ft_n), 0);
      // R6 read clears flag, interrupt stays
      step(0, 0, 0, 1); step(0, 0, 0, 0);
      chk("R6 flag cleared", 32'(wd_flag), 0);
      chk("R7 irq held", 32'(irq_ft_n), 0);
      // R7 zero write releases
      step(0, 1, 8'h00, 0); step(0, 0, 0, 0);
      chk("R7 irq released", 32'(irq_ft_n), 1);
      // R10 test waveform passes when idle, suppressed when watchdog aimed at pin
      ft_en = 1'b1; ft_wave = 1'b0;
      step(0, 0, 0, 0);
      chk("R10 ft passes", 32'(irq_ft_n), 0);
      step(0, 1, 8'h0D, 0); step(0, 0, 0, 0);
      chk("R10 watchdog owns pin", 32'(irq_ft_n), 1);
      ft_en = 1'b0;

      // R4: 0x08 -> limit 2 ticks; kick edge restarts
      step(0, 1, 8'h08, 0); step(0, 0, 0, 0);
      ticks(1);
      kick = ~kick;
      repeat (4) step(0, 0, 0, 0);
      ticks(1);
      chk("R4 kick restarted", 32'(wd_flag), 0);
      ticks(1);
      chk("R4 expiry after restart", 32'(wd_flag), 1);
      step(0, 0, 0, 1); step(0, 1, 8'h00, 0); step(0, 0, 0, 0);

      // R8 / R9: 0x84 -> steering 1, limit 1 tick
      step(0, 1, 8'h84, 0); step(0, 0, 0, 0);
      step(1, 0, 0, 0); step(0, 0, 0, 0);
      chk("R8 pulse low", 32'(rst_out_n), 0);
      chk("R9 cfg cleared", 32'(cfg_q), 0);
      chk("R9 ft_clr high", 32'(ft_clr), 1);
      step(0, 0, 0, 0);
      chk("R9 ft_clr one cycle", 32'(ft_clr), 0);
      ticks(1);
      chk("R8 pulse after 1 tick", 32'(rst_out_n), 0);
      ticks(1);
      chk("R8 pulse ends", 32'(rst_out_n), 1);
      step(0, 0, 0, 1); step(0, 0, 0, 0);

      // R3: multiplier zero never expires
      step(0, 1, 8'h03, 0); step(0, 0, 0, 0);
      ticks(20);
      chk("R3 no expiry", 32'(wd_flag), 0);

      // R5: write in the completing tick cycle cancels the timeout
      step(0, 1, 8'h04, 0); step(0, 0, 0, 0);
      step(1, 1, 8'h04, 0); step(0, 0, 0, 0);
      chk("R5 write cancels", 32'(wd_flag), 0);
      ticks(1);
      chk("R5 later expiry", 32'(wd_flag), 1);
      step(0, 0, 0, 1); step(0, 1, 8'h00, 0);

      // constrained random phase checked against the model
      for (int n = 0; n < 40000; n++) begin
         logic [7:0] d;
         d = {1'($urandom), 5'($urandom % 4), 2'($urandom)};
         if ($urandom % 8 == 0) d = 8'h00;
         if ($urandom % 500 == 0)  kick = ~kick;
         if ($urandom % 1000 == 0) ft_en = ~ft_en;
         if ($urandom % 7 == 0)    ft_wave = ~ft_wave;
         step(1'($urandom % 3 == 0), 1'($urandom % 1500 == 0), d,
              1'($urandom % 60 == 0));
      end
      step(0, 0, 0, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule